// File: doc/BRIEF.md
# I2C Slave with Measurement Readback

This block is the two-wire serial front end of an on-screen-display controller. It watches an oversampled clock line and data line, recognises bus start and stop conditions, and answers to one fixed 7-bit device address. In a write transaction it acknowledges the address and every following byte. It hands each byte to a downstream row/column/data command decoder as a single-cycle strobe, and it flags the first byte of each packet.

In a read transaction the block streams a bank of read-only measurement registers to the master, one byte per acknowledge, starting from index 0. Once the bank is exhausted it returns a fixed dummy byte until the master ends the transfer. The register bank lives outside the block and is reached through an index/data read port. SDA is driven open-drain: the block only ever pulls the line low, through an output enable.

Top module: `osd_i2c_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, sda_oe, rx_valid and rx_sop are 0 and meas_idx is 0.
- R2: The block acknowledges the first byte after a START only when its upper seven bits equal 3Dh (address byte 7Ah for write, 7Bh for read; bit 0 = 1 means read). On any other address it drives nothing, and it neither acknowledges nor forwards bytes until the next START.
- R3: In a write transaction each byte after the address is taken MSB first. It appears on rx_byte with rx_valid high for exactly one cycle, and it is acknowledged by pulling SDA low during the ninth clock.
- R4: rx_sop is high together with rx_valid for the first data byte after a matching write address, and low for the later bytes of the same transaction.
- R5: In a read transaction the block sends measurement bytes 0, 1, 2, ... MSB first, fetching byte i through meas_idx = i, and advances for each byte the master acknowledges.
- R6: After the last of MEAS_BYTES measurement bytes, every further byte sent is 00h until a STOP, and meas_idx never exceeds MEAS_BYTES.
- R7: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.
- R8: A repeated START returns meas_idx to 0, so a following read starts again at byte 0, and a following write marks its first data byte with rx_sop.
- R9: sda_oe changes only on a cycle that follows a low synchronized SCL, or a detected START or STOP.
- R10: START is SDA falling and STOP is SDA rising while SCL is high, both taken after a two-flop synchronizer. A STOP in the middle of a byte abandons that byte without raising rx_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| rx_byte | output | 8 | Received write data byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| rx_sop | output | 1 | First byte of a packet, valid with rx_valid |
| meas_idx | output | $clog2(MEAS_BYTES+1) | Index into the measurement bank |
| meas_data | input | 8 | Measurement byte at meas_idx |

## Verification
The bus-condition detector and the bit engine compete in the slot after a master not-acknowledge. There the engine is winding down a read, and a repeated START has to reset the read pointer rather than let it run on. The bench provokes this by reading a few bytes, withholding the acknowledge, and issuing a repeated START before either a read or a write address. It judges the outcome by whether the next read begins at byte 0 again and whether the next write byte carries the packet-start mark. Mid-byte STOP and the release after a not-acknowledge are checked at the data line the master sees.

// File: rtl/osd_i2c_pkg.sv
package osd_i2c_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    LK_IDLE = 3'd0,
    LK_RX   = 3'd1,
    LK_ACK  = 3'd2,
    LK_TX   = 3'd3,
    LK_MACK = 3'd4
  } link_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe;
  logic [PW-1:0] sda_pipe;
  logic          scl_q;
  logic          sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_i};
      sda_pipe <= {sda_pipe[PW-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign scl_q = scl_pipe[SYNC_STAGES];
  assign sda_q = sda_pipe[SYNC_STAGES];

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_read_ptr.sv
module i2c_read_ptr #(
  parameter int MEAS_BYTES = 12,
  parameter int IDXW       = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            advance,
  output logic [IDXW-1:0] idx,
  output logic            at_end
);
  localparam logic [IDXW-1:0] LAST = IDXW'(MEAS_BYTES);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx <= '0;
    end else if (advance && idx != LAST) begin
      idx <= idx + 1'b1;
    end
  end

  assign at_end = (idx == LAST);
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import osd_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3D
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sda_s,
  input  logic  scl_rise,
  input  logic  scl_fall,
  input  logic  start_det,
  input  logic  stop_det,
  input  byte_t tx_byte,
  output logic  sda_oe,
  output byte_t rx_byte,
  output logic  rx_valid,
  output logic  rx_sop,
  output logic  ptr_advance
);
  link_state_t state;
  logic [3:0]  bit_cnt;
  byte_t       shreg;
  logic        is_read;
  logic        addr_phase;
  logic        sop_pend;
  logic        master_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= LK_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      is_read     <= 1'b0;
      addr_phase  <= 1'b0;
      sop_pend    <= 1'b0;
      master_ack  <= 1'b0;
      sda_oe      <= 1'b0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      rx_sop      <= 1'b0;
      ptr_advance <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      rx_sop      <= 1'b0;
      ptr_advance <= 1'b0;
      if (start_det) begin
        state      <= LK_RX;
        bit_cnt    <= '0;
        addr_phase <= 1'b1;
        sop_pend   <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (stop_det) begin
        state  <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          LK_RX: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (addr_phase) begin
                addr_phase <= 1'b0;
                if (shreg[7:1] == DEV_ADDR) begin
                  is_read  <= shreg[0];
                  sop_pend <= ~shreg[0];
                  sda_oe   <= 1'b1;
                  state    <= LK_ACK;
                end else begin
                  state <= LK_IDLE;
                end
              end else begin
                rx_byte  <= shreg;
                rx_valid <= 1'b1;
                rx_sop   <= sop_pend;
                sop_pend <= 1'b0;
                sda_oe   <= 1'b1;
                state    <= LK_ACK;
              end
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                sda_oe      <= ~tx_byte[7];
                shreg       <= {tx_byte[6:0], 1'b0};
                ptr_advance <= 1'b1;
                state       <= LK_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= LK_RX;
              end
            end
          end
          LK_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= LK_MACK;
              end else begin
                sda_oe <= ~shreg[7];
                shreg  <= {shreg[6:0], 1'b0};
              end
            end
          end
          LK_MACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (master_ack) begin
                bit_cnt     <= '0;
                sda_oe      <= ~tx_byte[7];
                shreg       <= {tx_byte[6:0], 1'b0};
                ptr_advance <= 1'b1;
                state       <= LK_TX;
              end else begin
                state <= LK_IDLE;
              end
            end
          end
          default: begin
            state  <= LK_IDLE;
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/osd_i2c_slave.sv
module osd_i2c_slave
  import osd_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3D,
  parameter int         MEAS_BYTES  = 12,
  parameter logic [7:0] DUMMY_BYTE  = 8'h00,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDXW        = $clog2(MEAS_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [7:0]      rx_byte,
  output logic            rx_valid,
  output logic            rx_sop,
  output logic [IDXW-1:0] meas_idx,
  input  logic [7:0]      meas_data
);
  logic  scl_s;
  logic  sda_s;
  logic  scl_rise;
  logic  scl_fall;
  logic  start_det;
  logic  stop_det;
  logic  ptr_advance;
  logic  ptr_at_end;
  byte_t tx_byte;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_read_ptr #(.MEAS_BYTES(MEAS_BYTES), .IDXW(IDXW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .clear   (start_det),
    .advance (ptr_advance),
    .idx     (meas_idx),
    .at_end  (ptr_at_end)
  );

  assign tx_byte = ptr_at_end ? DUMMY_BYTE : meas_data;

  i2c_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .tx_byte     (tx_byte),
    .sda_oe      (sda_oe),
    .rx_byte     (rx_byte),
    .rx_valid    (rx_valid),
    .rx_sop      (rx_sop),
    .ptr_advance (ptr_advance)
  );
endmodule

// File: rtl/osd_i2c_slave_chk.sv
module osd_i2c_slave_chk #(
  parameter int MEAS_BYTES = 12,
  parameter int IDXW       = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            scl_s,
  input logic            start_det,
  input logic            stop_det,
  input logic            sda_oe,
  input logic            rx_valid,
  input logic            rx_sop,
  input logic [IDXW-1:0] meas_idx
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sda_oe && !rx_valid && !rx_sop && meas_idx == '0));

  // R9
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(!scl_s) || $past(start_det) || $past(stop_det)));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R3
  ack_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> sda_oe);

  // R4
  sop_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rx_sop |-> rx_valid);

  // R8
  start_ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (meas_idx == '0));

  // R6
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    meas_idx <= IDXW'(MEAS_BYTES));
endmodule

bind osd_i2c_slave osd_i2c_slave_chk #(.MEAS_BYTES(MEAS_BYTES), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .rx_valid  (rx_valid),
  .rx_sop    (rx_sop),
  .meas_idx  (meas_idx)
);

// File: tb/sim_osd_i2c_slave.sv
`timescale 1ns/1ps
module sim_osd_i2c_slave;
  localparam int NMEAS = 12;
  localparam int HP    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       rx_sop;
  logic [3:0] meas_idx;
  logic [7:0] meas_data;
  logic       sda_line;

  int n_tests = 0;
  int n_fail  = 0;
  int n_log   = 0;
  int oe_viol = 0;
  bit done    = 0;
  logic [7:0] log_b [0:31];
  logic       log_s [0:31];
  logic       oe_prev = 1'b0;

  always #10 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign meas_data = (meas_idx < NMEAS) ? {meas_idx, ~meas_idx} : 8'hFF;

  osd_i2c_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .meas_idx(meas_idx), .meas_data(meas_data)
  );

  function automatic logic [7:0] exp_meas(int i);
    logic [3:0] k = 4'(i);
    return (i < NMEAS) ? {k, ~k} : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!rst && rx_valid && n_log < 32) begin
      log_b[n_log] = rx_byte;
      log_s[n_log] = rx_sop;
      n_log++;
    end
    if (!rst && sda_oe != oe_prev && scl_m) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HP);
    scl_m = 1'b1; wt(HP);
    sda_m = 1'b0; wt(HP);
    scl_m = 1'b0; wt(HP);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HP);
    scl_m = 1'b1; wt(HP);
    sda_m = 1'b1; wt(HP);
  endtask

  task automatic send_bit(logic b);
    sda_m = b;    wt(HP);
    scl_m = 1'b1; wt(HP);
    scl_m = 1'b0; wt(HP);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wt(HP);
    scl_m = 1'b1; wt(HP/2);
    b = sda_line; wt(HP/2);
    scl_m = 1'b0; wt(HP);
  endtask

  task automatic write_byte(logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = ~a;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~ack);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rx_sop", rx_sop, 0);
    chk("R1 meas_idx", meas_idx, 0);
  endtask

  task automatic t_write();
    logic a;
    int base = n_log;
    logic [7:0] pat [3] = '{8'h3C, 8'hA5, 8'h81};
    bus_start();
    write_byte(8'h7A, a); chk("R2 write address ack", a, 1);
    for (int i = 0; i < 3; i++) begin
      write_byte(pat[i], a); chk("R3 data ack", a, 1);
    end
    bus_stop();
    chk("R3 byte count", n_log - base, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 byte value", log_b[base+i], pat[i]);
      chk("R4 sop flag", log_s[base+i], (i == 0));
    end
  endtask

  task automatic t_wrong_addr();
    logic a;
    int base = n_log;
    bus_start();
    write_byte(8'h70, a); chk("R2 foreign address nack", a, 0);
    write_byte(8'h7A, a); chk("R2 later byte not acked", a, 0);
    write_byte(8'h55, a); chk("R2 later byte not acked", a, 0);
    bus_stop();
    chk("R2 nothing forwarded", n_log - base, 0);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    bus_start();
    write_byte(8'h7B, a); chk("R2 read address ack", a, 1);
    for (int i = 0; i < NMEAS; i++) begin
      read_byte(d, 1'b1); chk("R5 measurement byte", d, exp_meas(i));
    end
    read_byte(d, 1'b1); chk("R6 dummy byte", d, 8'h00);
    chk("R6 index bound", meas_idx, NMEAS);
    read_byte(d, 1'b0); chk("R6 dummy byte last", d, 8'h00);
    read_byte(d, 1'b0); chk("R7 released after nack", d, 8'hFF);
    chk("R7 sda_oe idle", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_restart();
    logic a;
    logic [7:0] d;
    int base;
    bus_start();
    write_byte(8'h7B, a);
    read_byte(d, 1'b1); chk("R5 byte0", d, exp_meas(0));
    read_byte(d, 1'b1); chk("R5 byte1", d, exp_meas(1));
    read_byte(d, 1'b0); chk("R5 byte2", d, exp_meas(2));
    bus_start();
    chk("R8 index cleared", meas_idx, 0);
    write_byte(8'h7B, a); chk("R8 read re-address ack", a, 1);
    read_byte(d, 1'b0); chk("R8 restarts at byte0", d, exp_meas(0));
    base = n_log;
    bus_start();
    write_byte(8'h7A, a);
    write_byte(8'h11, a);
    write_byte(8'h22, a);
    bus_start();
    write_byte(8'h7A, a);
    write_byte(8'h33, a);
    bus_stop();
    chk("R8 bytes seen", n_log - base, 3);
    chk("R8 first sop", log_s[base], 1);
    chk("R8 second no sop", log_s[base+1], 0);
    chk("R8 new packet sop", log_s[base+2], 1);
    chk("R8 new packet data", log_b[base+2], 8'h33);
  endtask

  task automatic t_abort();
    logic a;
    int base = n_log;
    bus_start();
    write_byte(8'h7A, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    chk("R10 partial byte dropped", n_log - base, 0);
    chk("R10 line released", sda_oe, 0);
    bus_start();
    write_byte(8'h7A, a); chk("R10 fresh start ack", a, 1);
    write_byte(8'hC3, a);
    bus_stop();
    chk("R10 fresh byte", log_b[base], 8'hC3);
    chk("R10 fresh sop", log_s[base], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wt(4);
    t_reset();
    rst = 1'b0;
    wt(4);
    t_write();
    t_wrong_addr();
    t_read();
    t_restart();
    t_abort();
    chk("R9 sda_oe moves only with scl low", oe_viol, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule